// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls one port of up to eight identical pin slices. A CPU writes an output latch and per-pin configuration through a small single-cycle register bus. For every pin the block produces four pad controls: strong high, strong low, weak pull-up and weak pull-down. A 2-bit drive mode per pin decides how the latched bit maps onto those controls. Modes that mix a strong level with a resistive level let external circuitry override the weak side of the pin.

Pin levels pass through a two-flop synchronizer. The synchronized levels serve three purposes: they are returned when the CPU reads the data address, they are forwarded to an internal digital peripheral, and they feed per-pin edge detectors. A read of the data address returns the pin level and not the latch. A read-modify-write can therefore copy an externally pulled-high bit into the latch, and that pin then stays strongly high. A bypass bit per pin replaces the latch with the peripheral's output as the data source. Sticky per-pin pending flags, masked by enable bits, are ORed into one interrupt line.

The design has no state machine. It is made of registers, a read multiplexer and per-slice combinational drive decoders.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, all four pad controls are 0 for every pin (high impedance), `irq` is 0 and `rdata` is 0. The latch, bypass, enable, edge-select and pending bits reset to 0.
- R2: A write to address 0 stores `wdata` in the output latch. In mode 00 a latched 1 asserts `drv_hi` and a latched 0 asserts `drv_lo`. The outputs change in the cycle after the write.
- R3: The mode of pin i is {bit i of address 2, bit i of address 1}. The modes are:
  - 00: a 1 drives strong high and a 0 drives strong low.
  - 01: a 1 drives strong high and a 0 applies only a pull-down.
  - 10: no control is asserted.
  - 11: a 1 applies only a pull-up and a 0 drives strong low.
- R4: A read with `rd_en` high returns its value on `rdata` in the next cycle, and `rdata` holds while `rd_en` is low. Reading address 0 returns the pin levels delayed by two synchronizer flops. Reading addresses 1 to 6 returns the stored register (address 6 returns the pending flags). Reading address 7 returns 0.
- R5: A pin in mode 01 with a latched 0 that is pulled high externally reads back as 1. Writing that read value back latches a 1, so the pin stays strongly high after the external pull is removed.
- R6: Bit i of address 3 set selects `periph_out[i]` as the pin's data source in place of the latch. `periph_in` always carries the synchronized pin levels.
- R7: Bit i of address 5 set selects a rising edge and clear selects a falling edge. A matching edge on the synchronized level of pin i sets pending bit i one cycle after the edge is seen.
- R8: Writing address 6 clears every pending bit whose `wdata` bit is 1. Bits written 0 are unchanged. A new edge in the same cycle as a clear leaves the bit set.
- R9: `irq` is the OR of (pending AND enable), where the enable bits are at address 4. `irq` is asserted whenever at least one enabled pin is pending.
- R10: No pin ever asserts a strong control together with the opposite control (strong or weak), and no pin asserts both weak controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| pin_in | input | 8 | Pad input levels |
| periph_out | input | 8 | Digital peripheral output, used for bypassed pins |
| periph_in | output | 8 | Synchronized pin levels to the peripheral |
| drv_hi | output | 8 | Strong high enable per pin |
| drv_lo | output | 8 | Strong low enable per pin |
| pull_up | output | 8 | Weak pull-up enable per pin |
| pull_dn | output | 8 | Weak pull-down enable per pin |
| irq | output | 1 | Port interrupt |

## Verification
The assertions check the following on every cycle:
- that no pin has conflicting pad controls;
- that high-impedance pins stay quiet;
- that pending bits stay sticky unless cleared;
- that a matching edge always sets its pending bit;
- that `rdata` is stable without a read;
- that `irq` falls only after a clear or an enable change;
- that the port is quiet right after reset.

Only the bench's scenarios show the following, because they depend on a model of the external pads:
- the read-modify-write latch-up with an external pull;
- the two-cycle lag of read data behind the pins;
- bypass routing;
- a set and a clear landing in the same cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PORT_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        DM_STRONG = 2'b00,
        DM_S1_R0  = 2'b01,
        DM_HIZ    = 2'b10,
        DM_R1_S0  = 2'b11
    } drv_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_DATA    = 3'd0,
        RA_MODE_LO = 3'd1,
        RA_MODE_HI = 3'd2,
        RA_BYPASS  = 3'd3,
        RA_IRQ_EN  = 3'd4,
        RA_EDGE    = 3'd5,
        RA_PEND    = 3'd6,
        RA_NONE    = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_slice.sv
module gpio_slice
    import gpio_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  drv_mode_e mode,
    input  logic      out_bit,
    input  logic      lvl,
    input  logic      rise_sel,
    input  logic      clr,
    output logic      drv_hi,
    output logic      drv_lo,
    output logic      pull_up,
    output logic      pull_dn,
    output logic      pend
);
    logic lvl_d;
    logic hit;

    always_comb begin
        drv_hi  = 1'b0;
        drv_lo  = 1'b0;
        pull_up = 1'b0;
        pull_dn = 1'b0;
        unique case (mode)
            DM_STRONG: begin drv_hi = out_bit;  drv_lo  = ~out_bit; end
            DM_S1_R0:  begin drv_hi = out_bit;  pull_dn = ~out_bit; end
            DM_HIZ:    begin end
            DM_R1_S0:  begin pull_up = out_bit; drv_lo  = ~out_bit; end
            default:   begin end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl;
    end

    assign hit = rise_sel ? (lvl & ~lvl_d) : (~lvl & lvl_d);

    always_ff @(posedge clk) begin
        if (!rst_n)   pend <= 1'b0;
        else if (hit) pend <= 1'b1;
        else if (clr) pend <= 1'b0;
    end

    AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n) !((drv_hi && (drv_lo || pull_dn)) || (drv_lo && pull_up) || (pull_up && pull_dn))); // R10
    AST_HIZ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (mode == DM_HIZ) |-> !(drv_hi || drv_lo || pull_up || pull_dn)); // R3
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (pend && !clr) |=> pend); // R8
    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n) ((rise_sel && lvl && !lvl_d) || (!rise_sel && !lvl && lvl_d)) |=> pend); // R7
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int N         = PORT_W,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    output logic [N-1:0]      rdata,
    input  logic [N-1:0]      pin_in,
    input  logic [N-1:0]      periph_out,
    output logic [N-1:0]      periph_in,
    output logic [N-1:0]      drv_hi,
    output logic [N-1:0]      drv_lo,
    output logic [N-1:0]      pull_up,
    output logic [N-1:0]      pull_dn,
    output logic              irq
);
    logic [N-1:0] data_q, mlo_q, mhi_q, byp_q, ien_q, edge_q;
    logic [N-1:0] lvl, pend, clr_vec, src;
    logic [N-1:0] rd_mux;
    reg_addr_e    ra;

    assign ra = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            mlo_q  <= '0;
            mhi_q  <= {N{1'b1}};
            byp_q  <= '0;
            ien_q  <= '0;
            edge_q <= '0;
        end else if (wr_en) begin
            unique case (ra)
                RA_DATA:    data_q <= wdata;
                RA_MODE_LO: mlo_q  <= wdata;
                RA_MODE_HI: mhi_q  <= wdata;
                RA_BYPASS:  byp_q  <= wdata;
                RA_IRQ_EN:  ien_q  <= wdata;
                RA_EDGE:    edge_q <= wdata;
                default:    begin end
            endcase
        end
    end

    assign clr_vec = (wr_en && ra == RA_PEND) ? wdata : '0;

    always_comb begin
        unique case (ra)
            RA_DATA:    rd_mux = lvl;
            RA_MODE_LO: rd_mux = mlo_q;
            RA_MODE_HI: rd_mux = mhi_q;
            RA_BYPASS:  rd_mux = byp_q;
            RA_IRQ_EN:  rd_mux = ien_q;
            RA_EDGE:    rd_mux = edge_q;
            RA_PEND:    rd_mux = pend;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    gpio_sync #(.W(N), .STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (lvl)
    );

    assign periph_in = lvl;
    assign src       = (byp_q & periph_out) | (~byp_q & data_q);

    generate
        for (genvar i = 0; i < N; i++) begin : g_slice
            gpio_slice u_slice (
                .clk      (clk),
                .rst_n    (rst_n),
                .mode     (drv_mode_e'({mhi_q[i], mlo_q[i]})),
                .out_bit  (src[i]),
                .lvl      (lvl[i]),
                .rise_sel (edge_q[i]),
                .clr      (clr_vec[i]),
                .drv_hi   (drv_hi[i]),
                .drv_lo   (drv_lo[i]),
                .pull_up  (pull_up[i]),
                .pull_dn  (pull_dn[i]),
                .pend     (pend[i])
            );
        end
    endgenerate

    assign irq = |(pend & ien_q);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> ((drv_hi | drv_lo | pull_up | pull_dn) == '0) && !irq); // R1
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> $stable(rdata)); // R4
    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(irq) |-> $past(wr_en) && ($past(addr) == RA_PEND || $past(addr) == RA_IRQ_EN)); // R9
endmodule

// File: tb/sim_gpio_port_ctrl.sv
module sim_gpio_port_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [N-1:0] wdata = '0, periph_out = '0, ext_up = '0, ext_dn = '0;
    logic [N-1:0] rdata, periph_in, drv_hi, drv_lo, pull_up, pull_dn, pins;
    logic irq;
    int checks = 0, errors = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pad resolution: strong drive wins, then external pulls, then internal pull-up; floating reads 0
    always_comb begin
        for (int i = 0; i < N; i++)
            pins[i] = drv_hi[i] ? 1'b1 : drv_lo[i] ? 1'b0 : ext_up[i] ? 1'b1 :
                      ext_dn[i] ? 1'b0 : pull_up[i];
    end

    gpio_port_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pins), .periph_out(periph_out),
        .periph_in(periph_in), .drv_hi(drv_hi), .drv_lo(drv_lo),
        .pull_up(pull_up), .pull_dn(pull_dn), .irq(irq)
    );

    // Behavioural reference model
    logic [N-1:0] m_lat, m_lo, m_hi, m_byp, m_ien, m_edge, m_pend, m_rd;
    logic [N-1:0] m_s1, m_s2, m_prev, m_hit;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lat = 0; m_lo = 0; m_hi = '1; m_byp = 0; m_ien = 0; m_edge = 0;
            m_pend = 0; m_rd = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
        end else begin
            if (rd_en) begin
                case (addr)
                    3'd0: m_rd = m_s2;
                    3'd1: m_rd = m_lo;
                    3'd2: m_rd = m_hi;
                    3'd3: m_rd = m_byp;
                    3'd4: m_rd = m_ien;
                    3'd5: m_rd = m_edge;
                    3'd6: m_rd = m_pend;
                    default: m_rd = 0;
                endcase
            end
            for (int i = 0; i < N; i++)
                m_hit[i] = m_edge[i] ? (m_s2[i] && !m_prev[i]) : (!m_s2[i] && m_prev[i]);
            if (wr_en) begin
                case (addr)
                    3'd0: m_lat = wdata;
                    3'd1: m_lo = wdata;
                    3'd2: m_hi = wdata;
                    3'd3: m_byp = wdata;
                    3'd4: m_ien = wdata;
                    3'd5: m_edge = wdata;
                    3'd6: m_pend = m_pend & ~wdata;
                    default: ;
                endcase
            end
            m_pend = m_pend | m_hit;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        logic [N-1:0] eh, el, eu, ed;
        logic src;
        #1;
        eh = 0; el = 0; eu = 0; ed = 0;
        for (int i = 0; i < N; i++) begin
            src = m_byp[i] ? periph_out[i] : m_lat[i];
            case ({m_hi[i], m_lo[i]})
                2'b00: begin eh[i] = src;  el[i] = !src; end
                2'b01: begin eh[i] = src;  ed[i] = !src; end
                2'b10: ;
                default: begin eu[i] = src; el[i] = !src; end
            endcase
        end
        chk(drv_hi == eh,  "R2/R3/R6 drv_hi", drv_hi, eh);
        chk(drv_lo == el,  "R2/R3 drv_lo", drv_lo, el);
        chk(pull_up == eu, "R3 pull_up", pull_up, eu);
        chk(pull_dn == ed, "R3 pull_dn", pull_dn, ed);
        chk(rdata == m_rd, "R4 rdata", rdata, m_rd);
        chk(periph_in == m_s2, "R6 periph_in", periph_in, m_s2);
        chk(irq == |(m_pend & m_ien), "R9 irq", {7'd0, irq}, {7'd0, |(m_pend & m_ien)});
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            finish_run();
        end
    end

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        #2 v = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    initial begin
        logic [N-1:0] v;
        idle(3);
        chk((drv_hi | drv_lo | pull_up | pull_dn) == 0, "R1 hiz in reset", drv_hi | drv_lo | pull_up | pull_dn, 0);
        chk(irq == 0 && rdata == 0, "R1 irq/rdata in reset", rdata, 0);
        @(negedge clk); rst_n = 1'b1;
        idle(1);
        chk((drv_hi | drv_lo | pull_up | pull_dn) == 0, "R1 hiz after reset", drv_hi | drv_lo | pull_up | pull_dn, 0);

        // R2 strong mode
        wr(3'd2, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'hA5);
        idle(1);
        chk(drv_hi == 8'hA5 && drv_lo == 8'h5A, "R2 strong drive", drv_hi, 8'hA5);
        idle(4);
        rd(3'd0, v); chk(v == 8'hA5, "R4 pin readback", v, 8'hA5);

        // R3 mixed modes and readback
        wr(3'd1, 8'hAA); wr(3'd2, 8'hCC); wr(3'd0, 8'hF0);
        idle(4);
        rd(3'd2, v); chk(v == 8'hCC, "R4 mode readback", v, 8'hCC);
        rd(3'd7, v); chk(v == 8'h00, "R4 unused address", v, 8'h00);

        // R5 read-modify-write latch-up, all pins strong-1 / resistive-0
        wr(3'd2, 8'h00); wr(3'd1, 8'hFF); wr(3'd0, 8'h00);
        ext_up = 8'h08;
        idle(4);
        rd(3'd0, v); chk(v == 8'h08, "R5 pulled bit read", v, 8'h08);
        wr(3'd0, v | 8'h80);
        idle(4);
        ext_up = 8'h00;
        idle(4);
        rd(3'd0, v); chk(v == 8'h88, "R5 bit latched high", v, 8'h88);
        chk(drv_hi == 8'h88, "R5 strong high kept", drv_hi, 8'h88);

        // R6 bypass
        wr(3'd1, 8'h00); wr(3'd0, 8'h0F); wr(3'd3, 8'hF0);
        periph_out = 8'h3C;
        idle(4);
        chk(drv_hi == 8'h3F, "R6 bypass source", drv_hi, 8'h3F);
        chk(periph_in == 8'h3F, "R6 periph_in", periph_in, 8'h3F);
        wr(3'd3, 8'h00); periph_out = 8'h00;

        // R7/R8/R9 interrupts, pins input-only
        wr(3'd1, 8'h00); wr(3'd2, 8'hFF);
        idle(4);
        wr(3'd5, 8'h01); wr(3'd4, 8'h03); wr(3'd6, 8'hFF);
        idle(1);
        chk(irq == 0, "R9 cleared irq", {7'd0, irq}, 0);
        // rising edge on bit 0 collides with a clear of bit 0
        @(negedge clk); ext_up[0] = 1'b1;
        @(negedge clk);
        @(negedge clk); addr = 3'd6; wdata = 8'h01; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        #2;
        chk(irq == 1, "R8 set beats clear", {7'd0, irq}, 1);
        rd(3'd6, v); chk(v == 8'h01, "R7 rising pend", v, 8'h01);
        wr(3'd6, 8'h02);
        rd(3'd6, v); chk(v == 8'h01, "R8 write of 0 keeps bit", v, 8'h01);
        wr(3'd6, 8'h01);
        idle(1);
        chk(irq == 0, "R8 clear drops irq", {7'd0, irq}, 0);
        // falling edge select on bit 1
        ext_up[1] = 1'b1; idle(4);
        rd(3'd6, v); chk(v == 8'h00, "R7 rising ignored on falling select", v, 8'h00);
        ext_up[1] = 1'b0; idle(4);
        rd(3'd6, v); chk(v == 8'h02, "R7 falling pend", v, 8'h02);
        chk(irq == 1, "R9 enabled pend irq", {7'd0, irq}, 1);
        wr(3'd4, 8'h01);
        idle(1);
        chk(irq == 0, "R9 masked pend", {7'd0, irq}, 0);
        idle(3);
        finish_run();
    end
endmodule